// File: doc/BRIEF.md
# Cartridge Bank Switching Address Translator

This block sits between an 8-bit console's CPU and video buses and the ROM chips of a cartridge. It turns a 32 KiB CPU program window into four 8 KiB slots and an 8 KiB video pattern window into eight 1 KiB pages. Each slot and each page is then pointed at a bank of a larger ROM. Software steers the mapping by writing to the upper half of the CPU address space. Those writes fill a select register, eight bank registers and a nametable mirroring flag.

Two program slots are fixed. The last slot always holds the final ROM bank. The second-to-last ROM bank moves between slot 0 and slot 2 under a mode bit. The character window has one half of 2 KiB pairs and one half of single 1 KiB banks. A layout bit swaps which half is which. Address translation is combinational. Only the register writes are clocked.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, every register reads as zero: program mode 0, no character inversion, all bank registers 0 and vertical mirroring (mirror output 0).
- R2: A strobed write with address bits [15:13] = 100 and bit 0 = 0 loads the select register. Select bit 6 is the program mode and bit 7 is the character inversion.
- R3: A strobed write with address bits [15:13] = 100 and bit 0 = 1 loads bank register number select[2:0] with the data byte.
- R4: In program mode 0, slots 0, 1, 2 and 3 map to bank register 6, bank register 7, the second-to-last ROM bank and the last ROM bank.
- R5: In program mode 1, slots 0, 1, 2 and 3 map to the second-to-last ROM bank, bank register 7, bank register 6 and the last ROM bank.
- R6: With a one-bank ROM, the second-to-last bank is bank 0.
- R7: The program slot is CPU address bits [14:13]. The output address is {bank, cpu address [12:0]}. The character page is bits [12:10] and the output is {bank, address [9:0]}.
- R8: With inversion clear, pages 0/1 use bank register 0 with bit 0 cleared and then set. Pages 2/3 do the same with bank register 1. Pages 4 to 7 use bank registers 2 to 5.
- R9: With inversion set, the page layout is rotated by four. The single banks from registers 2 to 5 land on pages 0 to 3, and the pairs land on pages 4 to 7.
- R10: A strobed write with address bits [15:13] = 101 and bit 0 = 0 sets the mirror output to data bit 0 (1 = horizontal, 0 = vertical).
- R11: Every computed bank number is reduced modulo the ROM's bank count before it forms the output address.
- R12: Writes with the strobe low, or to any other address (the odd 101 register, 110, 111, or below 0x8000), change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 16 | CPU write address |
| wr_data_i | input | 8 | CPU write data |
| cpu_addr_i | input | 16 | CPU program read address |
| prg_addr_o | output | PRG_AW | Translated program ROM address |
| chr_addr_i | input | 13 | Video pattern address |
| chr_addr_o | output | CHR_AW | Translated character ROM address |
| mirror_horiz_o | output | 1 | Mirroring mode, 1 = horizontal |

## Verification
The bench builds two instances that share the same stimulus.

The first has 6 program banks and 40 character banks. Neither count is a power of two, so this instance runs the true modulo path. Its second-to-last bank (4) is distinct from the last, and bank register values from 6 to 255 show the wrap.

The second has 1 program bank and 8 character banks. It reaches the one-bank collapse of both fixed banks and the bit-slice wrap used for power-of-two counts.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned RAW_W    = 16;

  typedef logic [NUM_REGS-1:0][7:0] bank_file_t;

  function automatic int unsigned bank_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bank_wrap.sv
module bank_wrap #(
  parameter int unsigned N  = 6,
  parameter int unsigned OW = 3
) (
  input  logic [cart_map_pkg::RAW_W-1:0] raw_i,
  output logic [OW-1:0]                  bank_o
);
  logic unused_raw;
  assign unused_raw = ^raw_i;

  generate
    if (N == 1) begin : g_single
      assign bank_o = '0;
    end else if ((N & (N - 1)) == 0) begin : g_pow2
      assign bank_o = raw_i[OW-1:0];
    end else begin : g_mod
      assign bank_o = OW'(int'(raw_i) % int'(N));
    end
  endgenerate
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [2:0]               wr_region_i,
  input  logic                     wr_odd_i,
  input  logic [7:0]               wr_data_i,
  output logic [7:0]               sel_o,
  output cart_map_pkg::bank_file_t banks_o,
  output logic                     mirror_o
);
  logic sel_we, bank_we, mir_we;

  assign sel_we  = wr_en_i && (wr_region_i == 3'b100) && !wr_odd_i;
  assign bank_we = wr_en_i && (wr_region_i == 3'b100) &&  wr_odd_i;
  assign mir_we  = wr_en_i && (wr_region_i == 3'b101) && !wr_odd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= '0;
      banks_o  <= '0;
      mirror_o <= 1'b0;
    end else begin
      if (sel_we)  sel_o <= wr_data_i;
      if (bank_we) banks_o[sel_o[2:0]] <= wr_data_i;
      if (mir_we)  mirror_o <= wr_data_i[0];
    end
  end
endmodule

// File: rtl/prg_xlat.sv
module prg_xlat #(
  parameter int unsigned PRG_BANKS = 6,
  parameter int unsigned PRG_BW    = 3
) (
  input  logic              mode_i,
  input  logic [7:0]        r6_i,
  input  logic [7:0]        r7_i,
  input  logic [1:0]        slot_i,
  input  logic [12:0]       offs_i,
  output logic [PRG_BW+12:0] addr_o
);
  import cart_map_pkg::*;

  localparam logic [RAW_W-1:0] LAST = RAW_W'(PRG_BANKS - 1);
  localparam logic [RAW_W-1:0] PENULT = (PRG_BANKS > 1) ? RAW_W'(PRG_BANKS - 2) : '0;

  logic [RAW_W-1:0]  raw;
  logic [PRG_BW-1:0] bank;

  always_comb begin
    unique case ({mode_i, slot_i})
      3'b000:  raw = RAW_W'(r6_i);
      3'b001:  raw = RAW_W'(r7_i);
      3'b010:  raw = PENULT;
      3'b100:  raw = PENULT;
      3'b101:  raw = RAW_W'(r7_i);
      3'b110:  raw = RAW_W'(r6_i);
      default: raw = LAST;
    endcase
  end

  bank_wrap #(.N(PRG_BANKS), .OW(PRG_BW)) u_wrap (.raw_i(raw), .bank_o(bank));

  assign addr_o = {bank, offs_i};
endmodule

// File: rtl/chr_xlat.sv
module chr_xlat #(
  parameter int unsigned CHR_BANKS = 40,
  parameter int unsigned CHR_BW    = 6
) (
  input  logic                     invert_i,
  input  cart_map_pkg::bank_file_t banks_i,
  input  logic [12:0]              addr_i,
  output logic [CHR_BW+9:0]        addr_o
);
  import cart_map_pkg::*;

  logic [7:0][7:0]   layout;
  logic [2:0]        page;
  logic [CHR_BW-1:0] bank;
  logic              unused_hi;

  assign unused_hi = ^{banks_i[7], banks_i[6]};

  generate
    for (genvar p = 0; p < 8; p++) begin : g_page
      if (p < 4) begin : g_pair
        assign layout[p] = {banks_i[p/2][7:1], 1'(p % 2)};
      end else begin : g_single
        assign layout[p] = banks_i[p-2];
      end
    end
  endgenerate

  // rotating an eight-entry table by four flips page bit 2
  assign page = addr_i[12:10] ^ {invert_i, 2'b00};

  bank_wrap #(.N(CHR_BANKS), .OW(CHR_BW)) u_wrap (
    .raw_i (RAW_W'(layout[page])),
    .bank_o(bank)
  );

  assign addr_o = {bank, addr_i[9:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int unsigned PRG_BANKS = 32,
  parameter int unsigned CHR_BANKS = 256,
  parameter int unsigned PRG_AW    = cart_map_pkg::bank_bits(PRG_BANKS) + 13,
  parameter int unsigned CHR_AW    = cart_map_pkg::bank_bits(CHR_BANKS) + 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [15:0]       cpu_addr_i,
  output logic [PRG_AW-1:0] prg_addr_o,
  input  logic [12:0]       chr_addr_i,
  output logic [CHR_AW-1:0] chr_addr_o,
  output logic              mirror_horiz_o
);
  import cart_map_pkg::*;

  localparam int unsigned PRG_BW = PRG_AW - 13;
  localparam int unsigned CHR_BW = CHR_AW - 10;

  logic [7:0] sel_q;
  bank_file_t banks_q;
  logic       mirror_q;
  logic       unused_bits;

  assign unused_bits = ^{wr_addr_i[12:1], cpu_addr_i[15], sel_q[5:3]};

  mapper_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_region_i(wr_addr_i[15:13]),
    .wr_odd_i   (wr_addr_i[0]),
    .wr_data_i  (wr_data_i),
    .sel_o      (sel_q),
    .banks_o    (banks_q),
    .mirror_o   (mirror_q)
  );

  prg_xlat #(.PRG_BANKS(PRG_BANKS), .PRG_BW(PRG_BW)) u_prg (
    .mode_i(sel_q[6]),
    .r6_i  (banks_q[6]),
    .r7_i  (banks_q[7]),
    .slot_i(cpu_addr_i[14:13]),
    .offs_i(cpu_addr_i[12:0]),
    .addr_o(prg_addr_o)
  );

  chr_xlat #(.CHR_BANKS(CHR_BANKS), .CHR_BW(CHR_BW)) u_chr (
    .invert_i(sel_q[7]),
    .banks_i (banks_q),
    .addr_i  (chr_addr_i),
    .addr_o  (chr_addr_o)
  );

  assign mirror_horiz_o = mirror_q;
endmodule

// File: rtl/cart_map_chk.sv
module cart_map_chk #(
  parameter int unsigned PRG_BANKS = 32,
  parameter int unsigned CHR_BANKS = 256,
  parameter int unsigned PRG_AW    = 18,
  parameter int unsigned CHR_AW    = 18
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [15:0]              wr_addr_i,
  input logic [7:0]               wr_data_i,
  input logic [15:0]              cpu_addr_i,
  input logic [PRG_AW-1:0]        prg_addr_o,
  input logic [12:0]              chr_addr_i,
  input logic [CHR_AW-1:0]        chr_addr_o,
  input logic                     mirror_horiz_o,
  input logic [7:0]               sel_i,
  input cart_map_pkg::bank_file_t banks_i
);
  logic sel_wr, bank_wr, mir_wr;
  assign sel_wr  = wr_en_i && wr_addr_i[15:13] == 3'b100 && !wr_addr_i[0];
  assign bank_wr = wr_en_i && wr_addr_i[15:13] == 3'b100 &&  wr_addr_i[0];
  assign mir_wr  = wr_en_i && wr_addr_i[15:13] == 3'b101 && !wr_addr_i[0];

  assert_sel_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr |=> sel_i == $past(wr_data_i));

  assert_bank_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_wr |=> banks_i[$past(sel_i[2:0])] == $past(wr_data_i));

  assert_mirror_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mir_wr |=> mirror_horiz_o == $past(wr_data_i[0]));

  assert_mirror_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mir_wr |=> $stable(mirror_horiz_o));

  assert_last_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[14:13] == 2'b11 |-> int'(prg_addr_o[PRG_AW-1:13]) == int'(PRG_BANKS - 1));

  assert_chr_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CHR_BANKS % 2 == 0 && chr_addr_i[12] == sel_i[7]) |-> chr_addr_o[10] == chr_addr_i[10]);

  assert_offset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_addr_o[9:0] == chr_addr_i[9:0] && prg_addr_o[12:0] == cpu_addr_i[12:0]);
endmodule

bind cart_bank_mapper cart_map_chk #(
  .PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .PRG_AW(PRG_AW), .CHR_AW(CHR_AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .cpu_addr_i(cpu_addr_i), .prg_addr_o(prg_addr_o),
  .chr_addr_i(chr_addr_i), .chr_addr_o(chr_addr_o), .mirror_horiz_o(mirror_horiz_o),
  .sel_i(sel_q), .banks_i(banks_q)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = 16'h8000;
  logic [12:0] chr_addr = '0;
  logic [15:0] prg0, chr0;
  logic [13:0] prg1;
  logic [12:0] chr1;
  logic        mir0, mir1;

  int n_tests = 0, n_fail = 0;
  logic [7:0] m_sel = '0;
  logic [7:0] m_bank [8];
  logic       m_mir = 1'b0;

  always #10 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(6), .CHR_BANKS(40)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cpu_addr_i(cpu_addr), .prg_addr_o(prg0), .chr_addr_i(chr_addr), .chr_addr_o(chr0),
    .mirror_horiz_o(mir0));

  cart_bank_mapper #(.PRG_BANKS(1), .CHR_BANKS(8)) dut1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .cpu_addr_i(cpu_addr), .prg_addr_o(prg1), .chr_addr_i(chr_addr), .chr_addr_o(chr1),
    .mirror_horiz_o(mir1));

  function automatic int prg_exp(int nb, logic [15:0] a);
    int last = nb - 1;
    int pen  = (nb > 1) ? nb - 2 : 0;
    int raw;
    case ({m_sel[6], a[14:13]})
      3'b000: raw = m_bank[6];
      3'b001: raw = m_bank[7];
      3'b010: raw = pen;
      3'b100: raw = pen;
      3'b101: raw = m_bank[7];
      3'b110: raw = m_bank[6];
      default: raw = last;
    endcase
    return (raw % nb) * 8192 + int'(a[12:0]);
  endfunction

  function automatic int chr_exp(int nb, logic [12:0] a);
    int pg = int'(a[12:10]);
    int raw;
    if (m_sel[7]) pg = pg ^ 4;
    if (pg < 4) raw = (int'(m_bank[pg/2]) & 254) + (pg % 2);
    else        raw = m_bank[pg-2];
    return (raw % nb) * 1024 + int'(a[9:0]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_wr(logic en, logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en && a[15:13] == 3'b100) begin
      if (!a[0]) m_sel = d;
      else       m_bank[m_sel[2:0]] = d;
    end
    if (en && a[15:13] == 3'b101 && !a[0]) m_mir = d[0];
  endtask

  task automatic probe_prg(string tag, logic [15:0] a);
    cpu_addr = a; #1;
    chk(tag, int'(prg0), prg_exp(6, a));
    chk(tag, int'(prg1), prg_exp(1, a));
  endtask

  task automatic probe_chr(string tag, logic [12:0] a);
    chr_addr = a; #1;
    chk(tag, int'(chr0), chr_exp(40, a));
    chk(tag, int'(chr1), chr_exp(8, a));
  endtask

  task automatic probe_mir(string tag);
    #1;
    chk(tag, int'(mir0), int'(m_mir));
    chk(tag, int'(mir1), int'(m_mir));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_bank[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    probe_mir("R1");
    for (int s = 0; s < 4; s++) probe_prg("R1", 16'h8000 | 16'(s * 16'h2000) | 16'h0123);
    for (int p = 0; p < 8; p++) probe_chr("R1", 13'(p * 1024 + 5));

    // R3 load bank registers through select
    for (int r = 0; r < 8; r++) begin
      do_wr(1'b1, 16'h8000, 8'(r));
      do_wr(1'b1, 16'h8001, 8'(8'd13 + 8'(r * 7)));
    end
    for (int p = 0; p < 8; p++) probe_chr("R8", 13'(p * 1024 + 17));
    for (int s = 0; s < 4; s++) probe_prg("R4", 16'h8000 | 16'(s * 16'h2000) | 16'h1ABC);

    // R2 mode bit, R5 swapped fixed bank, R6 one-bank collapse
    do_wr(1'b1, 16'h8000, 8'h40);
    for (int s = 0; s < 4; s++) probe_prg("R5", 16'h8000 | 16'(s * 16'h2000) | 16'h0007);
    cpu_addr = 16'h8000; #1;
    chk("R6", int'(prg1[13]), 0);
    chk("R2", int'(prg0[15:13]), 4);

    // R9 inversion
    do_wr(1'b1, 16'h8000, 8'h80);
    for (int p = 0; p < 8; p++) probe_chr("R9", 13'(p * 1024 + 999));

    // R11 out-of-range wrap
    do_wr(1'b1, 16'h8000, 8'h07);
    do_wr(1'b1, 16'h8001, 8'd200);
    probe_prg("R11", 16'hA055);
    do_wr(1'b1, 16'h8000, 8'h02);
    do_wr(1'b1, 16'h8001, 8'd255);
    probe_chr("R11", 13'h1000);

    // R10 mirroring
    do_wr(1'b1, 16'hA000, 8'h01);
    probe_mir("R10");
    do_wr(1'b1, 16'hBFFE, 8'hFE);
    probe_mir("R10");
    do_wr(1'b1, 16'hA002, 8'h03);
    probe_mir("R10");

    // R12 ignored writes
    do_wr(1'b1, 16'hA001, 8'h00);
    do_wr(1'b1, 16'hC000, 8'hC0);
    do_wr(1'b1, 16'hE001, 8'hC0);
    do_wr(1'b1, 16'h6000, 8'hC0);
    do_wr(1'b0, 16'h8000, 8'hC0);
    do_wr(1'b0, 16'h8001, 8'h77);
    do_wr(1'b0, 16'hA000, 8'h00);
    probe_mir("R12");
    for (int s = 0; s < 4; s++) probe_prg("R12", 16'h8000 | 16'(s * 16'h2000));
    for (int p = 0; p < 8; p++) probe_chr("R12", 13'(p * 1024));

    // constrained random
    for (int it = 0; it < 400; it++) begin
      logic [2:0]  reg3;
      logic [15:0] a;
      int k = int'($urandom % 8);
      reg3 = (k < 4) ? 3'b100 : (k < 6) ? 3'b101 : 3'($urandom);
      a = {reg3, 13'($urandom)};
      do_wr(($urandom % 8) != 0, a, 8'($urandom));
      probe_mir("R10");
      for (int j = 0; j < 2; j++) begin
        logic [15:0] pa = {1'b1, 15'($urandom)};
        probe_prg(m_sel[6] ? "R5" : "R4", pa);
        probe_chr(m_sel[7] ? "R9" : "R8", 13'($urandom));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule